// File: doc/BRIEF.md
# Dual-Read Single-Write Processor Register File

This block is the general-purpose register storage of a single-cycle processor core. It holds a parameterised number of words (32 words of 32 bits by default) and serves two operand reads and one result write at the same time. Each of the three ports has its own address input. This lets the core fetch both source operands and retire a destination value in the same cycle.

The read ports are purely combinational: a read word follows its index within the same cycle, and no output register sits in the path. A write lands in the selected word on the rising clock edge, and only while the write enable is high. Index 0 is the architectural zero register and reads as 0 on both ports whatever was written to it. A parameter chooses how that rule is built: either each read port forces 0 for index 0, or word 0 is a constant and writes to it are dropped. Both variants look the same at the ports. The general words have no reset. There is no forwarding from the write port to the read ports.

Top module: `trio_regfile`

## Requirements
- R1: The storage holds 32 independent 32-bit words, selected by 5-bit indices 0 to 31. Each word keeps the last value written to it.
- R2: Each read port is combinational. When its read index changes and no clock edge occurs, its read word shows the word at the new index within the same cycle.
- R3: On a rising clock edge with `wr_en` = 1, `wr_word` is stored in the word selected by `wr_idx`. From then on, both read ports return it for that index.
- R4: On a rising clock edge with `wr_en` = 0, no word changes, whatever `wr_idx` and `wr_word` are.
- R5: Read index 0 returns 32'h0 on both ports at all times, including right after a write to index 0 with nonzero data.
- R6: When a read index equals `wr_idx` while a write is pending, the read port shows the old contents until the clock edge and the new value after it. There is no bypass.
- R7: When both read indices are equal, both read words are identical.
- R8: A write changes only the selected word. All other words keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes take effect on the rising edge |
| wr_en | input | 1 | Write enable, active high |
| wr_idx | input | 5 | Index of the word to write |
| wr_word | input | 32 | Data to write |
| ra_idx | input | 5 | Index for read port A |
| rb_idx | input | 5 | Index for read port B |
| ra_word | output | 32 | Read data of port A, combinational |
| rb_word | output | 32 | Read data of port B, combinational |

## Verification
A directed fill gives every word a distinct value derived from its index, including word 0. A full sweep of both ports then shows that no two words alias and that the zero register hides its written value. Directed steps then:
- move a read index between edges, to separate combinational reads from registered ones;
- hold the write enable low while the write index and data toggle;
- read the index being written on both sides of the edge, to expose any bypass;
- point both read ports at one index.

A long seeded random run then mixes enabled and disabled writes to arbitrary indices, index 0 included, and compares both ports against a reference array after every edge.

// File: rtl/trio_regfile_pkg.sv
package trio_regfile_pkg;

  localparam int unsigned WORD_W  = 32;
  localparam int unsigned DEPTH   = 32;
  localparam int unsigned IDX_W   = $clog2(DEPTH);

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [IDX_W-1:0]  idx_t;

  // One-hot write select; all zero when the write is not enabled.
  function automatic logic [DEPTH-1:0] wr_select(input logic en, input idx_t idx);
    logic [DEPTH-1:0] sel;
    sel = '0;
    if (en) sel[idx] = 1'b1;
    return sel;
  endfunction

  // True when an index names the architectural zero register.
  function automatic logic is_zero_reg(input idx_t idx);
    return (idx == idx_t'(0));
  endfunction

endpackage

// File: rtl/trio_store.sv
module trio_store
  import trio_regfile_pkg::*;
#(
  parameter bit BLOCK_ZERO = 1'b0
) (
  input  logic             clk,
  input  logic [DEPTH-1:0] wr_sel,
  input  word_t            wr_word,
  output word_t            cells [DEPTH]
);

  genvar gi;
  generate
    for (gi = 0; gi < DEPTH; gi++) begin : g_cell
      if (BLOCK_ZERO && gi == 0) begin : g_const
        assign cells[gi] = '0;
      end else begin : g_flop
        word_t q;
        always_ff @(posedge clk) begin
          if (wr_sel[gi]) q <= wr_word;
        end
        assign cells[gi] = q;
      end
    end
  endgenerate

endmodule

// File: rtl/trio_read_port.sv
module trio_read_port
  import trio_regfile_pkg::*;
#(
  parameter bit FORCE_ZERO = 1'b1
) (
  input  word_t cells [DEPTH],
  input  idx_t  rd_idx,
  output logic  zero_hit,
  output word_t rd_word
);

  assign zero_hit = is_zero_reg(rd_idx);

  generate
    if (FORCE_ZERO) begin : g_mux
      assign rd_word = zero_hit ? '0 : cells[rd_idx];
    end else begin : g_plain
      assign rd_word = cells[rd_idx];
    end
  endgenerate

endmodule

// File: rtl/trio_regfile.sv
module trio_regfile
  import trio_regfile_pkg::*;
#(
  parameter bit ZERO_BY_BLOCK = 1'b0
) (
  input  logic        clk,
  input  logic        wr_en,
  input  logic [4:0]  wr_idx,
  input  logic [31:0] wr_word,
  input  logic [4:0]  ra_idx,
  input  logic [4:0]  rb_idx,
  output logic [31:0] ra_word,
  output logic [31:0] rb_word
);

  localparam int unsigned PORTS = 2;

  // Named internal events for the checker.
  logic [DEPTH-1:0] wr_sel;
  logic             wr_commit;
  logic [PORTS-1:0] zero_hit;
  word_t            cells [DEPTH];
  idx_t             rd_idx  [PORTS];
  word_t            rd_word [PORTS];

  always_comb begin
    wr_sel = wr_select(wr_en, wr_idx);
    if (ZERO_BY_BLOCK) wr_sel[0] = 1'b0;
  end

  assign wr_commit = |wr_sel;

  trio_store #(.BLOCK_ZERO(ZERO_BY_BLOCK)) i_store (
    .clk     (clk),
    .wr_sel  (wr_sel),
    .wr_word (wr_word),
    .cells   (cells)
  );

  assign rd_idx[0] = ra_idx;
  assign rd_idx[1] = rb_idx;

  genvar gp;
  generate
    for (gp = 0; gp < PORTS; gp++) begin : g_port
      trio_read_port #(.FORCE_ZERO(!ZERO_BY_BLOCK)) i_rd (
        .cells    (cells),
        .rd_idx   (rd_idx[gp]),
        .zero_hit (zero_hit[gp]),
        .rd_word  (rd_word[gp])
      );
    end
  endgenerate

  assign ra_word = rd_word[0];
  assign rb_word = rd_word[1];

endmodule

// File: rtl/trio_regfile_chk.sv
module trio_regfile_chk (
  input logic        clk,
  input logic        wr_en,
  input logic [4:0]  wr_idx,
  input logic [31:0] wr_word,
  input logic [4:0]  ra_idx,
  input logic [4:0]  rb_idx,
  input logic [31:0] ra_word,
  input logic [31:0] rb_word,
  input logic        wr_commit,
  input logic [1:0]  zero_hit
);

  // The block has no reset; checks start after the first edge.
  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= 1'b1;

  assert_zero_a_R5: assert property (@(posedge clk) disable iff (!armed)
    zero_hit[0] |-> ra_word == 32'h0);

  assert_zero_b_R5: assert property (@(posedge clk) disable iff (!armed)
    zero_hit[1] |-> rb_word == 32'h0);

  assert_same_idx_R7: assert property (@(posedge clk) disable iff (!armed)
    (ra_idx == rb_idx) |-> ra_word == rb_word);

  assert_hold_R4: assert property (@(posedge clk) disable iff (!armed)
    (!$past(wr_en) && $stable(ra_idx)) |-> $stable(ra_word));

  assert_commit_only_if_en_R4: assert property (@(posedge clk) disable iff (!armed)
    wr_commit |-> wr_en);

  assert_written_R3: assert property (@(posedge clk) disable iff (!armed)
    ($past(wr_en) && $past(wr_idx) != 5'd0 && ra_idx == $past(wr_idx))
      |-> ra_word == $past(wr_word));

endmodule

bind trio_regfile trio_regfile_chk i_chk (
  .clk       (clk),
  .wr_en     (wr_en),
  .wr_idx    (wr_idx),
  .wr_word   (wr_word),
  .ra_idx    (ra_idx),
  .rb_idx    (rb_idx),
  .ra_word   (ra_word),
  .rb_word   (rb_word),
  .wr_commit (wr_commit),
  .zero_hit  (zero_hit)
);

// File: tb/test_trio_regfile.sv
module test_trio_regfile;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_idx = '0;
  logic [31:0] wr_word = '0;
  logic [4:0]  ra_idx = '0;
  logic [4:0]  rb_idx = '0;
  logic [31:0] ra_word, rb_word;

  int n_tests = 0;
  int n_fail  = 0;
  logic [31:0] ref_mem [32];

  always #10 clk = ~clk;

  trio_regfile i_trio_regfile (
    .clk(clk), .wr_en(wr_en), .wr_idx(wr_idx), .wr_word(wr_word),
    .ra_idx(ra_idx), .rb_idx(rb_idx), .ra_word(ra_word), .rb_word(rb_word)
  );

  function automatic logic [31:0] expect_rd(input logic [4:0] idx);
    if (idx == 5'd0) return 32'h0;
    return ref_mem[idx];
  endfunction

  function automatic logic [31:0] fill_pattern(input int i);
    return 32'hC3000000 ^ (32'(i) * 32'h00010203) ^ 32'(i);
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // Drive at the falling edge, let the rising edge pass, settle.
  task automatic cycle(input logic en, input logic [4:0] wi, input logic [31:0] wd,
                       input logic [4:0] a, input logic [4:0] b);
    @(negedge clk);
    wr_en = en; wr_idx = wi; wr_word = wd; ra_idx = a; rb_idx = b;
    @(posedge clk);
    if (en) ref_mem[wi] = wd;
    #2;
  endtask

  task automatic sweep(input string req);
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      wr_en = 1'b0; ra_idx = 5'(i); rb_idx = 5'(31 - i);
      #1;
      check(req, ra_word, expect_rd(5'(i)));
      check(req, rb_word, expect_rd(5'(31 - i)));
    end
  endtask

  initial begin
    #(20 * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] old_v;
    void'($urandom(32'd1234));
    for (int i = 0; i < 32; i++) ref_mem[i] = '0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    #1;
    // R5: zero register before anything is written
    check("R5 reset-state port A", ra_word, 32'h0);
    check("R5 reset-state port B", rb_word, 32'h0);

    // R1/R8: directed fill with distinct values, including index 0
    for (int i = 0; i < 32; i++) cycle(1'b1, 5'(i), fill_pattern(i), 5'(i), 5'd0);
    sweep("R1 R8 R5 fill sweep");

    // R2: index change between edges
    @(negedge clk);
    wr_en = 1'b0; ra_idx = 5'd9;
    #1 check("R2 comb read A", ra_word, expect_rd(5'd9));
    ra_idx = 5'd22;
    #1 check("R2 comb read A moved", ra_word, expect_rd(5'd22));
    rb_idx = 5'd3;
    #1 check("R2 comb read B moved", rb_word, expect_rd(5'd3));

    // R4: enable low while index and data toggle
    for (int k = 0; k < 6; k++) cycle(1'b0, 5'($urandom), $urandom, 5'd1, 5'd2);
    sweep("R4 disabled writes");

    // R6: same-cycle read of the word being written
    @(negedge clk);
    old_v = expect_rd(5'd7);
    wr_en = 1'b1; wr_idx = 5'd7; wr_word = 32'hDEADBEEF; ra_idx = 5'd7; rb_idx = 5'd7;
    #1 check("R6 before edge A", ra_word, old_v);
    check("R6 before edge B", rb_word, old_v);
    @(posedge clk);
    ref_mem[7] = 32'hDEADBEEF;
    #2 check("R6 after edge A", ra_word, 32'hDEADBEEF);
    check("R6 after edge B", rb_word, 32'hDEADBEEF);

    // R5: nonzero write to index 0
    cycle(1'b1, 5'd0, 32'hFFFFFFFF, 5'd0, 5'd0);
    check("R5 after write A", ra_word, 32'h0);
    check("R5 after write B", rb_word, 32'h0);

    // R7: same index on both ports
    cycle(1'b0, 5'd0, 32'h0, 5'd17, 5'd17);
    check("R7 same index", ra_word, rb_word);
    check("R7 same index value", rb_word, expect_rd(5'd17));

    // R3/R8: seeded random traffic
    for (int k = 0; k < 3000; k++) begin
      logic [4:0] wi;
      wi = 5'($urandom);
      cycle(($urandom % 4) != 0, wi, $urandom,
            ((k % 5) == 0) ? wi : 5'($urandom), 5'($urandom));
      check("R3 R8 random A", ra_word, expect_rd(ra_idx));
      check("R3 R8 random B", rb_word, expect_rd(rb_idx));
    end
    sweep("R8 final sweep");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule